// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual page number into a physical page number by fetching one translation entry from memory. A requester offers a lookup that carries the virtual page number and an access kind: data load, data store or instruction fetch. The walker adds the page number, scaled by the entry size, to a base register that software reloads on every context switch. It issues a single read on a plain request/response memory port and then decodes the returned entry.

The decode first looks at the presence bit and then at the permission bits for the given access kind. The lookup ends with a one-cycle completion pulse that carries one of three outcomes: a physical page number, a not-present fault or a permission fault. When the lookup succeeds, the raw entry and its virtual page number are offered on a fill output in the same cycle, so that a translation buffer can install them. The physical address is the returned page number joined with the untouched page offset. With the default sizes (40-bit virtual address, 16 KiB pages, 36-bit physical address) the offset has 14 bits, the virtual page number 26 bits and the physical page number 22 bits.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `busy` is low, `req_ready` is high, and `mem_req_valid`, `done_valid` and `fill_valid` are low.
- R2: Each accepted lookup issues exactly one memory read, at address base + (vpn << 2) modulo 2^PA_W. The address stays stable while `mem_req_valid` is high and `mem_req_ready` is low, and `mem_req_valid` drops after the handshake.
- R3: A pulse on `base_we` loads `base_wdata` into the base register. Only lookups accepted in a later cycle use the new value. A write made while a walk is in flight leaves that walk's address unchanged.
- R4: Only one lookup is in flight at a time. `busy` rises in the cycle after acceptance and stays high until the completion cycle has passed. While busy, `req_ready` is low and `req_valid` is ignored, so no further memory read follows.
- R5: The entry layout: bit 0 means the page is present, bit 1 grants write, bit 2 grants execute, and bits 29:8 hold the physical page number. A load is allowed on any present page.
- R6: An entry with bit 0 clear ends in `done_pfault`=1, `done_xfault`=0, `done_ppn`=0 and no fill, whatever the access kind.
- R7: The access codes are 0 load, 1 store, 2 fetch and 3 reserved. On a present page, a store without the write bit, a fetch without the execute bit, or the reserved code ends in `done_xfault`=1, `done_pfault`=0, `done_ppn`=0 and no fill.
- R8: On success, `done_ppn` carries entry bits 29:8 with both fault flags low. `fill_valid` is high in the same single cycle as `done_valid`, with `fill_vpn` and `fill_pte` equal to the request's page number and the entry as read.
- R9: `done_valid` is a one-cycle pulse two clock edges after the edge that accepts the response. `mem_rsp_valid` is ignored unless a response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | PA_W | New table base address |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Walker can accept a lookup |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | PTE_W | Entry word |
| busy | output | 1 | Lookup in progress |
| done_valid | output | 1 | Lookup completed (one cycle) |
| done_ppn | output | PPN_W | Physical page number, zero on a fault |
| done_pfault | output | 1 | Page not present |
| done_xfault | output | 1 | Access not permitted |
| fill_valid | output | 1 | Entry ready for a translation buffer |
| fill_vpn | output | VPN_W | Page number that goes with the fill |
| fill_pte | output | PTE_W | Raw entry for the fill |

## Verification
The bench stalls the read handshake and delays the response. A walker that let the address drift, or that issued a second read, would show a changed `mem_req_addr` or a repeated `mem_req_valid`. Stray response pulses during the request phase and requests offered while busy are injected; a design that listened to them would decode the wrong entry or start an extra walk. Not-present entries with permission bits set, stores to read-only pages, fetches from non-executable pages and the reserved code each target a distinct fault path. A mis-prioritised or merged decode would raise the wrong flag, leak a page number or raise `fill_valid`. Base rewrites during a walk and a page number of all ones with a high base check the address sum, its wraparound and the point at which a new base takes effect.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_READ_REQ,
      S_WAIT_RESP,
      S_CHECK,
      S_DONE
   } walk_st_e;

   localparam int PTE_PRESENT_BIT = 0;
   localparam int PTE_WRITE_BIT   = 1;
   localparam int PTE_EXEC_BIT    = 2;
   localparam int PTE_PPN_LSB     = 8;

endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_walker_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     mem_req_ready,
   input  logic     mem_rsp_valid,
   output walk_st_e state,
   output logic     accept,
   output logic     rsp_take,
   output logic     check_en
);

   walk_st_e st_q, st_d;

   assign accept   = (st_q == S_IDLE) && req_valid;
   assign rsp_take = (st_q == S_WAIT_RESP) && mem_rsp_valid;
   assign check_en = (st_q == S_CHECK);
   assign state    = st_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:      if (req_valid)     st_d = S_READ_REQ;
         S_READ_REQ:  if (mem_req_ready) st_d = S_WAIT_RESP;
         S_WAIT_RESP: if (mem_rsp_valid) st_d = S_CHECK;
         S_CHECK:                        st_d = S_DONE;
         S_DONE:                         st_d = S_IDLE;
         default:                        st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int PA_W      = 36,
   parameter int VPN_W     = 26,
   parameter int PTE_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_we,
   input  logic [PA_W-1:0]  base_wdata,
   input  logic             accept,
   input  logic [VPN_W-1:0] vpn,
   output logic [PA_W-1:0]  entry_addr
);

   localparam int SH = $clog2(PTE_BYTES);

   logic [PA_W-1:0] base_q;
   logic [PA_W-1:0] scaled;
   logic [PA_W-1:0] addr_q;

   generate
      if (PA_W >= VPN_W) begin : g_wide
         assign scaled = PA_W'(vpn) << SH;
      end else begin : g_narrow
         assign scaled = vpn[PA_W-1:0] << SH;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         addr_q <= '0;
      end else begin
         if (base_we) base_q <= base_wdata;
         if (accept)  addr_q <= base_q + scaled;
      end
   end

   assign entry_addr = addr_q;

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
   import pt_walker_pkg::*;
#(
   parameter int PTE_W = 32,
   parameter int PPN_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PTE_W-1:0] pte,
   input  acc_e             acc,
   output logic             ok_o,
   output logic             pfault_o,
   output logic             xfault_o,
   output logic [PPN_W-1:0] ppn_o
);

   logic present, allowed;

   assign present = pte[PTE_PRESENT_BIT];

   always_comb begin
      unique case (acc)
         ACC_LOAD:  allowed = 1'b1;
         ACC_STORE: allowed = pte[PTE_WRITE_BIT];
         ACC_FETCH: allowed = pte[PTE_EXEC_BIT];
         default:   allowed = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_o     <= 1'b0;
         pfault_o <= 1'b0;
         xfault_o <= 1'b0;
         ppn_o    <= '0;
      end else if (en) begin
         ok_o     <= present && allowed;
         pfault_o <= !present;
         xfault_o <= present && !allowed;
         ppn_o    <= (present && allowed) ? pte[PTE_PPN_LSB +: PPN_W] : '0;
      end
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int VA_W       = 40,
   parameter int PA_W       = 36,
   parameter int PAGE_BYTES = 16384,
   parameter int PTE_BYTES  = 4,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int VPN_W     = VA_W - OFS_W,
   localparam int PPN_W     = PA_W - OFS_W,
   localparam int PTE_W     = PTE_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_we,
   input  logic [PA_W-1:0]  base_wdata,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [1:0]       req_acc,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             busy,
   output logic             done_valid,
   output logic [PPN_W-1:0] done_ppn,
   output logic             done_pfault,
   output logic             done_xfault,
   output logic             fill_valid,
   output logic [VPN_W-1:0] fill_vpn,
   output logic [PTE_W-1:0] fill_pte
);

   generate
      if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (PTE_BYTES != 4 && PTE_BYTES != 8) begin : g_bad_pte
         $error("PTE_BYTES must be 4 or 8");
      end
      if (PTE_PPN_LSB + PPN_W > PTE_W) begin : g_bad_ppn
         $error("physical page number does not fit in the entry");
      end
   endgenerate

   walk_st_e         state;
   logic             accept, rsp_take, check_en, ok;
   logic [VPN_W-1:0] vpn_q;
   acc_e             acc_q;
   logic [PTE_W-1:0] pte_q;

   pt_walk_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .state         (state),
      .accept        (accept),
      .rsp_take      (rsp_take),
      .check_en      (check_en)
   );

   pt_addr_gen #(
      .PA_W      (PA_W),
      .VPN_W     (VPN_W),
      .PTE_BYTES (PTE_BYTES)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_we    (base_we),
      .base_wdata (base_wdata),
      .accept     (accept),
      .vpn        (req_vpn),
      .entry_addr (mem_req_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpn_q <= '0;
         acc_q <= ACC_LOAD;
         pte_q <= '0;
      end else begin
         if (accept) begin
            vpn_q <= req_vpn;
            acc_q <= acc_e'(req_acc);
         end
         if (rsp_take) pte_q <= mem_rsp_data;
      end
   end

   pt_entry_check #(
      .PTE_W (PTE_W),
      .PPN_W (PPN_W)
   ) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (check_en),
      .pte      (pte_q),
      .acc      (acc_q),
      .ok_o     (ok),
      .pfault_o (done_pfault),
      .xfault_o (done_xfault),
      .ppn_o    (done_ppn)
   );

   assign busy          = (state != S_IDLE);
   assign req_ready     = !busy;
   assign mem_req_valid = (state == S_READ_REQ);
   assign done_valid    = (state == S_DONE);
   assign fill_valid    = done_valid && ok;
   assign fill_vpn      = vpn_q;
   assign fill_pte      = pte_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int PA_W  = 36,
   parameter int PPN_W = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             busy,
   input logic             done_valid,
   input logic [PPN_W-1:0] done_ppn,
   input logic             done_pfault,
   input logic             done_xfault,
   input logic             fill_valid
);

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);

   assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy && mem_req_valid);

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid && !done_valid);

   assert_pfault_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && done_pfault |-> !done_xfault && done_ppn == '0 && !fill_valid);

   assert_xfault_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && done_xfault |-> done_ppn == '0 && !fill_valid);

   assert_fill_only_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> done_valid && !done_pfault && !done_xfault);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid && !busy);

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .PPN_W(PPN_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .busy          (busy),
   .done_valid    (done_valid),
   .done_ppn      (done_ppn),
   .done_pfault   (done_pfault),
   .done_xfault   (done_xfault),
   .fill_valid    (fill_valid)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

   localparam int PA_W  = 36;
   localparam int VPN_W = 26;
   localparam int PPN_W = 22;
   localparam int PTE_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             base_we = 1'b0;
   logic [PA_W-1:0]  base_wdata = '0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [VPN_W-1:0] req_vpn = '0;
   logic [1:0]       req_acc = 2'd0;
   logic             mem_req_valid;
   logic             mem_req_ready = 1'b0;
   logic [PA_W-1:0]  mem_req_addr;
   logic             mem_rsp_valid = 1'b0;
   logic [PTE_W-1:0] mem_rsp_data = '0;
   logic             busy, done_valid, done_pfault, done_xfault, fill_valid;
   logic [PPN_W-1:0] done_ppn;
   logic [VPN_W-1:0] fill_vpn;
   logic [PTE_W-1:0] fill_pte;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;
   logic [PA_W-1:0] base_m = '0;

   always #10 clk = ~clk;

   pt_walker uut (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_acc(req_acc),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
      .done_valid(done_valid), .done_ppn(done_ppn), .done_pfault(done_pfault),
      .done_xfault(done_xfault), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic write_base(input logic [PA_W-1:0] v);
      base_we = 1'b1; base_wdata = v;
      @(negedge clk);
      base_we = 1'b0;
      base_m = v;
   endtask

   // one lookup; bench plays the memory and predicts the outcome from the requirements
   task automatic walk(input logic [VPN_W-1:0] vpn, input logic [1:0] acc,
                       input logic [PTE_W-1:0] pte, input int stall, input int dly,
                       input bit garbage, input bit poke, input bit mid_base,
                       input logic [PA_W-1:0] mid_val);
      logic [PA_W-1:0]  exp_addr;
      logic             present, allowed, e_pf, e_xf, e_ok;
      logic [PPN_W-1:0] e_ppn;
      exp_addr = base_m + ({10'd0, vpn} << 2);
      present  = pte[0];
      case (acc)
         2'd0: allowed = 1'b1;
         2'd1: allowed = pte[1];
         2'd2: allowed = pte[2];
         default: allowed = 1'b0;
      endcase
      e_pf  = !present;
      e_xf  = present && !allowed;
      e_ok  = present && allowed;
      e_ppn = e_ok ? pte[29:8] : '0;

      chk("R4 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_vpn = vpn; req_acc = acc;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R4 busy after accept", busy, 1);
      chk("R4 ready low while busy", req_ready, 0);
      chk("R2 read issued", mem_req_valid, 1);
      chk("R2 entry address", mem_req_addr, exp_addr);
      if (poke) begin
         req_valid = 1'b1; req_vpn = ~vpn; req_acc = 2'd0;
      end
      if (mid_base) begin
         write_base(mid_val);
         chk("R3 in-flight address kept", mem_req_addr, exp_addr);
      end
      for (int i = 0; i < stall; i++) begin
         if (garbage && i == 0) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = ~pte;
         end
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         chk("R2 request held", mem_req_valid, 1);
         chk("R2 address stable", mem_req_addr, exp_addr);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R2 single read", mem_req_valid, 0);
      for (int i = 0; i < dly; i++) begin
         @(negedge clk);
         chk("R9 no early done", done_valid, 0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      req_valid = 1'b0;
      chk("R9 done not yet", done_valid, 0);
      chk("R4 still busy", busy, 1);
      @(negedge clk);
      chk("R9 done pulse", done_valid, 1);
      chk("R6 page fault flag", done_pfault, e_pf);
      chk("R7 protection fault flag", done_xfault, e_xf);
      chk("R8 physical page number", done_ppn, e_ppn);
      chk("R8 fill valid", fill_valid, e_ok);
      if (e_ok) begin
         chk("R8 fill vpn", fill_vpn, vpn);
         chk("R8 fill entry", fill_pte, pte);
      end
      @(negedge clk);
      chk("R9 done one cycle", done_valid, 0);
      chk("R8 fill one cycle", fill_valid, 0);
      chk("R4 idle again", busy, 0);
      chk("R4 no extra read", mem_req_valid, 0);
   endtask

   function automatic logic [PTE_W-1:0] mk(input logic [21:0] ppn, input bit x, input bit w, input bit v);
      return {2'b00, ppn, 5'b00000, x, w, v};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy at reset", busy, 0);
      chk("R1 ready at reset", req_ready, 1);
      chk("R1 no read at reset", mem_req_valid, 0);
      chk("R1 no done at reset", done_valid, 0);
      chk("R1 no fill at reset", fill_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", busy, 0);

      write_base(36'h8_1234_5000);
      // R5 load on read-only present page
      walk(26'h0000123, 2'd0, mk(22'h2A_BCDE, 0, 0, 1), 0, 0, 0, 0, 0, '0);
      // R7 store on read-only page
      walk(26'h0000124, 2'd1, mk(22'h11_1111, 1, 0, 1), 1, 0, 0, 0, 0, '0);
      // R5 store on writable page with stalls and delay
      walk(26'h3FF_0001, 2'd1, mk(22'h3F_FFFF, 0, 1, 1), 2, 3, 0, 0, 0, '0);
      // R7 fetch without execute
      walk(26'h0000200, 2'd2, mk(22'h00_0F00, 0, 1, 1), 0, 1, 0, 0, 0, '0);
      // R5 fetch with execute
      walk(26'h0000201, 2'd2, mk(22'h15_5555, 1, 0, 1), 0, 0, 0, 0, 0, '0);
      // R6 not present, rights bits set, store
      walk(26'h0ABCDEF, 2'd1, mk(22'h2A_AAAA, 1, 1, 0), 1, 2, 0, 0, 0, '0);
      // R6 not present, load
      walk(26'h0000001, 2'd0, mk(22'h00_0001, 0, 0, 0), 0, 0, 0, 0, 0, '0);
      // R7 reserved access code on fully permitted page
      walk(26'h0000055, 2'd3, mk(22'h12_3456, 1, 1, 1), 0, 0, 0, 0, 0, '0);
      // R9 stray response during request phase; R4 request while busy ignored
      walk(26'h0000777, 2'd0, mk(22'h0C_0FFE, 0, 0, 1), 3, 2, 1, 1, 0, '0);
      // R3 base rewrite during a walk affects the next one only
      walk(26'h0000010, 2'd0, mk(22'h01_0203, 0, 0, 1), 2, 0, 0, 0, 1, 36'h0_0040_0000);
      walk(26'h0000010, 2'd0, mk(22'h04_0506, 0, 0, 1), 0, 0, 0, 0, 0, '0);
      // R2 wraparound: all-ones page number with a high base
      write_base(36'hF_FFFF_FF00);
      walk(26'h3FF_FFFF, 2'd0, mk(22'h3F_0001, 0, 0, 1), 1, 1, 0, 0, 0, '0);

      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule